// File: doc/BRIEF.md
# Serial PROM configuration boot controller

This controller loads a device's configuration by itself from an external serial EEPROM. No host takes part. It picks the configuration clock from one of two sources: an internal oscillator, whose clock it then drives out on the configuration clock pad, or a clock supplied on that pad. From the selected clock it makes the memory shift clock at half the rate. It drives the memory's active-low chip enable. It captures one serial data bit on each rising edge of the shift clock.

The captured stream holds, in order:
- a 16-bit sync word;
- a 16-bit payload length;
- the payload bits;
- an 8-bit checksum.

Each payload bit is written to the configuration memory through a bit-write port. A successful load ends with the chip enable released, the shift clock stopped and `done_o` held high. A bad sync word or a bad checksum halts the load and drives a shared open-drain error line low. The controller starts again on a release of the reset pin or on a falling edge of the re-boot request. Both of these inputs pass through two-flop synchronizers before their edges are detected.

Top module: `prom_boot_ctrl`

## Requirements
- R1: While `boot_en_i` is low, no load starts: `mem_ce_no` stays high and `done_o` stays low, even across a reset release.
- R2: With `ext_clk_i` low, `cfg_clk_oe_o` is 1 and the block runs from `osc_clk_i`. With `ext_clk_i` high, `cfg_clk_oe_o` is 0 and the block runs from `cfg_clk_i` alone.
- R3: While a load is active, `dclk_o` changes value on every edge of the selected clock, which gives half its frequency. When no load is active, `dclk_o` is held low.
- R4: After power-on reset, the block idles while `reset_n_i` is low: `mem_ce_no`=1, `dclk_o`=0, `done_o`=0, `err_oe_o`=0, `wr_en_o`=0. A release of `reset_n_i` starts a load, and `mem_ce_no` goes low.
- R5: The stream is read MSB first as the 16-bit sync word 16'hA5C3, then a 16-bit length L, then L payload bits, then an 8-bit checksum. One bit is taken per rising `dclk_o`.
- R6: Payload bit k (counting from 0) is written as a one-cycle `wr_en_o` pulse with `wr_addr_o`=k and `wr_data_o` set to the bit. The writes come in stream order, and no write occurs outside the payload.
- R7: The expected checksum is the XOR of the payload bytes: payload bit k toggles checksum bit 7-(k mod 8). On a match, `done_o`=1, `mem_ce_no`=1 and `dclk_o` stays low until the next restart.
- R8: A sync word mismatch, detected after 16 bits, or a checksum mismatch sets `err_oe_o`=1 and halts the load. While halted, `mem_ce_no`=1, `dclk_o` stays low and no writes occur. This lasts until the next restart.
- R9: A falling edge of `reboot_n_i` restarts the full load and clears `done_o` and `err_oe_o`. Holding `reboot_n_i` low afterwards causes no further restart.
- R10: `reset_n_i` low at any time forces idle and clears `done_o` and `err_oe_o`. Its rising edge restarts the load.
- R11: A length of zero goes straight to the checksum, which must then be 8'h00. No writes occur and `done_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| osc_clk_i | input | 1 | Internal oscillator clock |
| boot_en_i | input | 1 | Strap: self-boot from serial memory |
| ext_clk_i | input | 1 | Strap: 1 = configuration clock from pad |
| cfg_clk_i | input | 1 | Configuration clock pad, input side |
| cfg_clk_o | output | 1 | Configuration clock pad, output side |
| cfg_clk_oe_o | output | 1 | Configuration clock pad output enable |
| reset_n_i | input | 1 | Reset pin, active low |
| reboot_n_i | input | 1 | Re-boot request, falling edge active |
| dclk_o | output | 1 | Serial memory shift clock |
| mem_ce_no | output | 1 | Serial memory chip enable, active low |
| data_i | input | 1 | Serial memory data |
| err_oe_o | output | 1 | 1 = pull shared error line low |
| done_o | output | 1 | Load completed successfully |
| wr_en_o | output | 1 | Configuration bit write strobe |
| wr_addr_o | output | ADDR_W | Configuration bit address |
| wr_data_o | output | 1 | Configuration bit value |

## Verification
A bench-side serial memory model feeds the controller streams of several kinds:
- payloads of 24, 40, 32 and 16 bits, each with its own bit pattern, which separate address counting and bit ordering;
- a zero-length stream, which checks that the data phase can be skipped;
- a corrupted sync word and a corrupted final checksum bit, which show that the two error checks are distinct: the first error stops the load before any write, the second after all writes.

Separate restarts check the restart triggers and the clock-source straps:
- a re-boot edge after done, including a long hold low;
- a re-boot edge after an error;
- a reset in the middle of a load;
- a reset release with self-boot disabled;
- a load running on the pad clock with the oscillator stopped.

// File: rtl/prom_boot_pkg.sv
package prom_boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LEN,
    ST_DATA,
    ST_SUM,
    ST_DONE,
    ST_ERR
  } boot_state_e;
endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= RST_VAL;
      else if (g == 0) q[g] <= async_i;
      else q[g] <= q[(g == 0) ? 0 : g-1];
    end
  end

  assign level_o = q[STAGES-1];
endmodule

// File: rtl/boot_clk_sel.sv
module boot_clk_sel (
  input  logic osc_clk_i,
  input  logic pad_clk_i,
  input  logic ext_sel_i,
  output logic core_clk_o,
  output logic pad_clk_o,
  output logic pad_oe_o
);
  // ext_sel_i is a static strap; no glitch-free switch needed
  assign core_clk_o = ext_sel_i ? pad_clk_i : osc_clk_i;
  assign pad_clk_o  = osc_clk_i;
  assign pad_oe_o   = ~ext_sel_i;
endmodule

// File: rtl/boot_dclk_gen.sv
module boot_dclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic dclk_o,
  output logic bit_stb_o
);
  logic dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dclk_q <= 1'b0;
    else if (restart_i || !run_i) dclk_q <= 1'b0;
    else dclk_q <= ~dclk_q;
  end

  // bit taken on the edge that raises dclk
  assign bit_stb_o = run_i & ~dclk_q & ~restart_i;
  assign dclk_o    = dclk_q;

  AST_DCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i) |=> (dclk_q != $past(dclk_q))); // R3
  AST_DCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !dclk_q); // R3
endmodule

// File: rtl/boot_stream_fsm.sv
module boot_stream_fsm
  import prom_boot_pkg::*;
#(
  parameter int              SYNC_W    = 16,
  parameter int              LEN_W     = 16,
  parameter int              SUM_W     = 8,   // power of two
  parameter int              ADDR_W    = 16,  // <= LEN_W
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hA5C3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              restart_i,
  input  logic              bit_stb_i,
  input  logic              data_i,
  output logic              run_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_data_o
);
  localparam int SH_W   = (SYNC_W > LEN_W) ? SYNC_W : LEN_W;
  localparam int SUM_IW = $clog2(SUM_W);
  localparam logic [LEN_W-1:0]  SYNC_LAST = LEN_W'(SYNC_W - 1);
  localparam logic [LEN_W-1:0]  LEN_LAST  = LEN_W'(LEN_W - 1);
  localparam logic [LEN_W-1:0]  SUM_LAST  = LEN_W'(SUM_W - 1);
  localparam logic [SUM_IW-1:0] SUM_TOP   = SUM_IW'(SUM_W - 1);

  boot_state_e       state_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [SH_W-1:0]   sh_q, sh_nx;
  logic [SUM_W-1:0]  sum_q, sum_nx;
  logic [SUM_IW-1:0] sum_idx;
  logic              wr_en_q, wr_data_q;
  logic [ADDR_W-1:0] wr_addr_q;

  assign sh_nx   = {sh_q[SH_W-2:0], data_i};
  assign sum_idx = SUM_TOP - cnt_q[SUM_IW-1:0];

  always_comb begin
    sum_nx          = sum_q;
    sum_nx[sum_idx] = sum_q[sum_idx] ^ data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      sh_q      <= '0;
      sum_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (hold_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (restart_i) begin
        state_q <= ST_SYNC;
        cnt_q   <= '0;
        sh_q    <= '0;
        sum_q   <= '0;
      end else if (bit_stb_i) begin
        sh_q <= sh_nx;
        unique case (state_q)
          ST_SYNC: begin
            if (cnt_q == SYNC_LAST) begin
              cnt_q   <= '0;
              state_q <= (sh_nx[SYNC_W-1:0] == SYNC_WORD) ? ST_LEN : ST_ERR;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_LEN: begin
            if (cnt_q == LEN_LAST) begin
              cnt_q   <= '0;
              len_q   <= sh_nx[LEN_W-1:0];
              state_q <= (sh_nx[LEN_W-1:0] == '0) ? ST_SUM : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= cnt_q[ADDR_W-1:0];
            wr_data_q <= data_i;
            sum_q     <= sum_nx;
            if (cnt_q == len_q - 1'b1) begin
              cnt_q   <= '0;
              state_q <= ST_SUM;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_SUM: begin
            if (cnt_q == SUM_LAST) begin
              cnt_q   <= '0;
              state_q <= (sh_nx[SUM_W-1:0] == sum_q) ? ST_DONE : ST_ERR;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign run_o     = (state_q == ST_SYNC) || (state_q == ST_LEN) ||
                     (state_q == ST_DATA) || (state_q == ST_SUM);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = (state_q == ST_ERR);
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (state_q == ST_IDLE)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && !hold_i && !restart_i) |=> (state_q == ST_ERR)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !hold_i && !restart_i) |=> (state_q == ST_DONE)); // R7
  AST_WR_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA) |=> !wr_en_q); // R6
  AST_RESTART_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !hold_i) |=> (state_q == ST_SYNC)); // R9
endmodule

// File: rtl/prom_boot_ctrl.sv
module prom_boot_ctrl #(
  parameter int                SYNC_W    = 16,
  parameter int                LEN_W     = 16,
  parameter int                SUM_W     = 8,
  parameter int                ADDR_W    = 16,
  parameter int                SYNC_STG  = 2,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hA5C3
) (
  input  logic              rst_ni,
  input  logic              osc_clk_i,
  input  logic              boot_en_i,
  input  logic              ext_clk_i,
  input  logic              cfg_clk_i,
  output logic              cfg_clk_o,
  output logic              cfg_clk_oe_o,
  input  logic              reset_n_i,
  input  logic              reboot_n_i,
  output logic              dclk_o,
  output logic              mem_ce_no,
  input  logic              data_i,
  output logic              err_oe_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_data_o
);
  logic core_clk;
  logic rst_lvl, rst_prev, bfr_lvl, bfr_prev;
  logic rst_rise, bfr_fall, restart, hold;
  logic run, bit_stb, err;

  boot_clk_sel i_clk_sel (
    .osc_clk_i (osc_clk_i),
    .pad_clk_i (cfg_clk_i),
    .ext_sel_i (ext_clk_i),
    .core_clk_o(core_clk),
    .pad_clk_o (cfg_clk_o),
    .pad_oe_o  (cfg_clk_oe_o)
  );

  // reset pin syncs to 0 so a release already present at power-on gives an edge
  boot_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) i_sync_rst (
    .clk_i(core_clk), .rst_ni(rst_ni), .async_i(reset_n_i), .level_o(rst_lvl)
  );
  boot_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sync_bfr (
    .clk_i(core_clk), .rst_ni(rst_ni), .async_i(reboot_n_i), .level_o(bfr_lvl)
  );

  always_ff @(posedge core_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_prev <= 1'b0;
      bfr_prev <= 1'b1;
    end else begin
      rst_prev <= rst_lvl;
      bfr_prev <= bfr_lvl;
    end
  end

  assign rst_rise = rst_lvl & ~rst_prev;
  assign bfr_fall = bfr_prev & ~bfr_lvl;
  assign hold     = ~rst_lvl | ~boot_en_i;
  assign restart  = ~hold & (rst_rise | bfr_fall);

  boot_dclk_gen i_dclk (
    .clk_i    (core_clk),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(restart),
    .dclk_o   (dclk_o),
    .bit_stb_o(bit_stb)
  );

  boot_stream_fsm #(
    .SYNC_W(SYNC_W), .LEN_W(LEN_W), .SUM_W(SUM_W),
    .ADDR_W(ADDR_W), .SYNC_WORD(SYNC_WORD)
  ) i_fsm (
    .clk_i    (core_clk),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .restart_i(restart),
    .bit_stb_i(bit_stb),
    .data_i   (data_i),
    .run_o    (run),
    .done_o   (done_o),
    .err_o    (err),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  assign mem_ce_no = ~run;
  assign err_oe_o  = err;

  AST_ERR_HALTED: assert property (@(posedge core_clk) disable iff (!rst_ni)
    err_oe_o |-> (mem_ce_no && !done_o)); // R8
  AST_BFR_ONE_SHOT: assert property (@(posedge core_clk) disable iff (!rst_ni)
    bfr_fall |=> !bfr_fall); // R9
  AST_NO_BOOT_DISABLED: assert property (@(posedge core_clk) disable iff (!rst_ni)
    !boot_en_i |=> mem_ce_no); // R1
endmodule

// File: tb/test_prom_boot_ctrl.sv
`timescale 1ns/1ps
module test_prom_boot_ctrl;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, boot_en, ext_clk, reset_n, reboot_n, osc_run, pad_run;
  logic osc_clk, pad_clk, data;
  logic cfg_clk_o, cfg_clk_oe, dclk, mem_ce_n, err_oe, done, wr_en, wr_data;
  logic [AW-1:0] wr_addr;

  assign osc_clk = clk & osc_run;
  assign pad_clk = clk & pad_run;

  prom_boot_ctrl i_prom_boot_ctrl (
    .rst_ni(rst_ni), .osc_clk_i(osc_clk), .boot_en_i(boot_en), .ext_clk_i(ext_clk),
    .cfg_clk_i(pad_clk), .cfg_clk_o(cfg_clk_o), .cfg_clk_oe_o(cfg_clk_oe),
    .reset_n_i(reset_n), .reboot_n_i(reboot_n), .dclk_o(dclk), .mem_ce_no(mem_ce_n),
    .data_i(data), .err_oe_o(err_oe), .done_o(done), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  // serial memory model
  logic sbits [0:255];
  int   slen = 0;
  int   idx  = 0;
  always @(posedge dclk or posedge mem_ce_n) begin
    if (mem_ce_n) idx <= 0;
    else idx <= idx + 1;
  end
  assign data = (idx < slen) ? sbits[idx] : 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [AW:0] expq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: builds a stream and pushes the expected writes (R5, R6, R7)
  task automatic build(input int plen, input int seed, input bit bad_sync, input bit bad_sum);
    logic [15:0] sw;
    logic [15:0] ln;
    logic [7:0]  cs;
    sw = 16'hA5C3;
    ln = 16'(plen);
    cs = 8'h00;
    for (int i = 0; i < 16; i++) sbits[i] = sw[15-i];
    for (int i = 0; i < 16; i++) sbits[16+i] = ln[15-i];
    for (int i = 0; i < plen; i++) begin
      logic b;
      b = (((i * 13 + seed * 7) % 5) < 2);
      sbits[32+i] = b;
      cs[7 - (i % 8)] = cs[7 - (i % 8)] ^ b;
      if (!bad_sync) expq.push_back({AW'(i), b});
    end
    for (int i = 0; i < 8; i++) sbits[32+plen+i] = cs[7-i];
    slen = 40 + plen;
    if (bad_sync) sbits[3] = ~sbits[3];
    if (bad_sum) sbits[slen-1] = ~sbits[slen-1];
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && wr_en) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6", "unexpected write addr", int'(wr_addr), -1);
      end else begin
        logic [AW:0] e;
        e = expq.pop_front();
        chk({wr_addr, wr_data} == e, "R6", "write addr/data", int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reboot();
    reboot_n = 1'b0;
    cyc(4);
    reboot_n = 1'b1;
  endtask

  task automatic wait_end(input string req);
    int k;
    k = 0;
    @(negedge clk);
    while (!(done || err_oe) && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 3000, req, "load finished before timeout", k, 3000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; boot_en = 1'b1; ext_clk = 1'b0; reset_n = 1'b0;
    reboot_n = 1'b1; osc_run = 1'b1; pad_run = 1'b0;
    cyc(5);
    chk(mem_ce_n && !dclk && !done && !err_oe && !wr_en, "R4", "state in power-on reset",
        {mem_ce_n, dclk, done, err_oe, wr_en}, 5'b10000);
    rst_ni = 1'b1;
    cyc(20);
    chk(mem_ce_n && !dclk && !done && !err_oe, "R4", "idle while reset pin low",
        {mem_ce_n, dclk, done, err_oe}, 4'b1000);
    chk(cfg_clk_oe == 1'b1, "R2", "pad output enable in oscillator mode", cfg_clk_oe, 1);

    // A: basic load on reset release
    build(24, 1, 1'b0, 1'b0);
    reset_n = 1'b1;
    begin
      int k;
      k = 0;
      while (mem_ce_n && k < 20) begin
        @(negedge clk);
        k++;
      end
      chk(!mem_ce_n, "R4", "chip enable asserted after release", mem_ce_n, 0);
    end
    begin
      logic prev;
      bit ok;
      ok = 1'b1;
      prev = dclk;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (dclk == prev) ok = 1'b0;
        prev = dclk;
      end
      chk(ok, "R3", "shift clock toggles every clock", ok, 1);
    end
    wait_end("R5");
    chk(done && !err_oe && mem_ce_n, "R7", "done after good load",
        {done, err_oe, mem_ce_n}, 3'b101);
    begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (dclk || !done) ok = 1'b0;
      end
      chk(ok, "R3", "shift clock idle low after done", ok, 1);
    end
    chk(expq.size() == 0, "R6", "all payload bits written", expq.size(), 0);

    // B: re-boot edge, then long hold low
    build(40, 2, 1'b0, 1'b0);
    reboot_n = 1'b0;
    cyc(6);
    chk(!done, "R9", "done cleared by re-boot edge", done, 0);
    wait_end("R9");
    chk(done && !err_oe, "R9", "re-boot load completes", {done, err_oe}, 2'b10);
    begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!done || !mem_ce_n) ok = 1'b0;
      end
      chk(ok, "R9", "holding re-boot low has no effect", ok, 1);
    end
    reboot_n = 1'b1;
    cyc(5);
    chk(expq.size() == 0, "R6", "re-boot payload written", expq.size(), 0);

    // C: bad sync word
    build(16, 3, 1'b1, 1'b0);
    pulse_reboot();
    wait_end("R8");
    chk(err_oe && !done && mem_ce_n, "R8", "sync mismatch halts with error",
        {err_oe, done, mem_ce_n}, 3'b101);
    begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!err_oe || dclk || !mem_ce_n) ok = 1'b0;
      end
      chk(ok, "R8", "halted state kept after sync error", ok, 1);
    end
    chk(expq.size() == 0, "R8", "no writes after sync error", expq.size(), 0);

    // D: bad checksum, restart from error
    build(32, 4, 1'b0, 1'b1);
    pulse_reboot();
    cyc(2);
    chk(!err_oe, "R9", "error cleared by re-boot", err_oe, 0);
    wait_end("R8");
    chk(err_oe && !done, "R8", "checksum mismatch flags error", {err_oe, done}, 2'b10);
    chk(expq.size() == 0, "R6", "payload written before checksum error", expq.size(), 0);

    // E: zero-length stream
    build(0, 5, 1'b0, 1'b0);
    pulse_reboot();
    wait_end("R11");
    chk(done && !err_oe, "R11", "zero length load done", {done, err_oe}, 2'b10);

    // F: reset during load
    build(24, 6, 1'b0, 1'b0);
    pulse_reboot();
    cyc(26);
    reset_n = 1'b0;
    cyc(5);
    chk(mem_ce_n && !done && !err_oe && !dclk, "R10", "reset pin forces idle mid-load",
        {mem_ce_n, done, err_oe, dclk}, 4'b1000);
    expq.delete();
    cyc(20);
    chk(mem_ce_n, "R10", "stays idle while reset low", mem_ce_n, 1);
    build(24, 6, 1'b0, 1'b0);
    reset_n = 1'b1;
    wait_end("R10");
    chk(done && !err_oe, "R10", "reset release restarts load", {done, err_oe}, 2'b10);
    chk(expq.size() == 0, "R10", "restarted payload written", expq.size(), 0);

    // G: self-boot disabled
    boot_en = 1'b0;
    reset_n = 1'b0;
    cyc(4);
    reset_n = 1'b1;
    begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!mem_ce_n || done) ok = 1'b0;
      end
      chk(ok, "R1", "no load with self-boot disabled", ok, 1);
    end
    boot_en = 1'b1;

    // H: external pad clock, oscillator stopped
    ext_clk = 1'b1;
    pad_run = 1'b1;
    osc_run = 1'b0;
    cyc(2);
    chk(cfg_clk_oe == 1'b0, "R2", "pad output enable in external mode", cfg_clk_oe, 0);
    build(16, 7, 1'b0, 1'b0);
    pulse_reboot();
    wait_end("R2");
    chk(done && !err_oe, "R2", "load runs from pad clock", {done, err_oe}, 2'b10);
    chk(expq.size() == 0, "R2", "pad clock payload written", expq.size(), 0);

    summary();
    $finish;
  end
endmodule